// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Step Unit

This block produces the next value of a post-incremented address pointer. In circular mode, it adds a signed offset to the current pointer and keeps the result inside a buffer window. The window is taken from one of two sources, selected by fields of a 32-bit modifier word:

- **Explicit window:** the window starts at a separate base register and spans the encoded length.
- **Legacy window:** the window is the power-of-two aligned block around the current pointer, with its top set by OR-ing in the length.

A result that falls outside the window is corrected once, by adding or subtracting the buffer length.

In bit-reverse mode, the block mirrors the low half of the pointer and passes the upper half through unchanged.

A caller presents one request with `in_valid`. The block registers the result and raises `out_valid` for exactly one cycle on the next edge. The memory access that uses the pointer is outside the block, and so is any check on the range of the offset. An offset whose magnitude exceeds the buffer length gives a result that has no meaning, because only one wrap correction is applied.

The control is a two-state machine:

- `ST_IDLE`: no result is being presented. The transition *accept* (`in_valid` high) leads to `ST_EMIT`.
- `ST_EMIT`: a fresh result is on `out_ptr`. The transition *accept* keeps it in `ST_EMIT` with a new result. The transition *drain* (`in_valid` low) returns it to `ST_IDLE`.

Top module: `addr_step_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_ptr` is 0.
- R2: `out_valid` is 1 in exactly those cycles that follow a clock edge at which `in_valid` was 1. In a cycle after an edge with `in_valid` at 0, `out_ptr` keeps its previous value.
- R3: Circular mode decodes only two fields of `modifier`: the window selector K in bits 27:24 and the buffer length L in bits 16:0. Bits 31:28 and 23:17 have no effect on the result.
- R4: When K equals 0 and L is at least 4, the window start S is `circ_base` and the window end E is `circ_base + L`, taken modulo 2^32.
- R5: In every other case, including K equal to 0 with L below 4, a mask of 2^(K+2)-1 applies. S is `ptr` with the mask bits cleared, and E is S OR L.
- R6: The candidate pointer C is `ptr + offset` modulo 2^32. If C is greater than or equal to E, the result is C - L.
- R7: If C is less than S (and not at or above E), the result is C + L. Otherwise the result is C. All comparisons treat S, E and C as unsigned 32-bit values.
- R8: `mode` 0 selects circular update. `mode` 1 selects bit reverse: result bit i equals `ptr` bit 15-i for i from 0 to 15, and result bits 31:16 equal `ptr` bits 31:16. In this mode, `offset`, `modifier` and `circ_base` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; the inputs below are sampled when it is high |
| mode | input | 1 | 0 = circular update, 1 = bit reverse of the low half |
| ptr | input | 32 | Current pointer value |
| offset | input | 32 | Signed increment, two's complement |
| modifier | input | 32 | Window selector K in bits 27:24, buffer length L in bits 16:0 |
| circ_base | input | 32 | Window start used by the explicit window |
| out_valid | output | 1 | High for one cycle when `out_ptr` carries a new result |
| out_ptr | output | 32 | Updated pointer |

## Verification
The hardest cases to reach are the branch boundaries. These are:

- a candidate pointer that lands exactly on the window end;
- a candidate pointer that lands one below the window start;
- the legacy window in which K is 0 and L is below 4, where the window is taken from the pointer rather than from `circ_base`.

The stimulus sweeps every K value against lengths at and around 4, and at the full 17-bit limit. It places the pointer at the first, middle and last slot of the window, and applies offsets of plus and minus the full length as well as small steps. These choices make each comparison land on both sides of its boundary.

Random requests then fill in the space between those boundaries, with offsets limited to the buffer length. Other requests set the ignored modifier bits, or switch to bit-reverse mode while carrying junk on the circular inputs.

// File: rtl/addr_step_pkg.sv
package addr_step_pkg;

    // Operating mode selected on the mode input.
    typedef enum logic {
        MODE_CIRC = 1'b0,
        MODE_BREV = 1'b1
    } step_mode_e;

    // Output control states.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } step_state_e;

    // Default field geometry of the modifier word.
    localparam int unsigned DEF_ADDR_W  = 32;
    localparam int unsigned DEF_SEL_LSB = 24;
    localparam int unsigned DEF_SEL_W   = 4;
    localparam int unsigned DEF_LEN_W   = 17;
    localparam int unsigned DEF_MIN_LEN = 4;

endpackage

// File: rtl/step_window.sv
module step_window #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned LEN_W   = 17,
    parameter int unsigned MIN_LEN = 4
) (
    input  logic [SEL_W-1:0]  sel_k,
    input  logic [LEN_W-1:0]  buf_len,
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [ADDR_W-1:0] base_reg,
    output logic [ADDR_W-1:0] win_lo,
    output logic [ADDR_W-1:0] win_hi
);
    localparam int unsigned SH_W = SEL_W + 1;

    logic              use_base;
    logic [SH_W-1:0]   sh_amt;
    logic [ADDR_W-1:0] align_mask;
    logic [ADDR_W-1:0] len_ext;
    logic [ADDR_W-1:0] legacy_lo;

    always_comb begin
        len_ext    = ADDR_W'(buf_len);
        use_base   = (sel_k == '0) && (buf_len >= LEN_W'(MIN_LEN));
        sh_amt     = SH_W'(sel_k) + SH_W'(2);
        align_mask = ~({ADDR_W{1'b1}} << sh_amt);
        legacy_lo  = cur_ptr & ~align_mask;
        if (use_base) begin
            win_lo = base_reg;
            win_hi = base_reg + len_ext;
        end else begin
            win_lo = legacy_lo;
            win_hi = legacy_lo | len_ext;
        end
    end
endmodule

// File: rtl/step_wrap.sv
module step_wrap #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 17
) (
    input  logic [ADDR_W-1:0] cur_ptr,
    input  logic [ADDR_W-1:0] incr,
    input  logic [LEN_W-1:0]  buf_len,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_hi,
    output logic [ADDR_W-1:0] next_ptr
);
    logic [ADDR_W-1:0] cand;
    logic [ADDR_W-1:0] len_ext;

    always_comb begin
        len_ext = ADDR_W'(buf_len);
        cand    = cur_ptr + incr;
        if (cand >= win_hi) begin
            next_ptr = cand - len_ext;
        end else if (cand < win_lo) begin
            next_ptr = cand + len_ext;
        end else begin
            next_ptr = cand;
        end
    end
endmodule

// File: rtl/step_bitrev.sv
module step_bitrev #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned REV_W  = 16
) (
    input  logic [ADDR_W-1:0] cur_ptr,
    output logic [ADDR_W-1:0] rev_ptr
);
    for (genvar gi = 0; gi < REV_W; gi++) begin : g_mirror
        assign rev_ptr[gi] = cur_ptr[REV_W-1-gi];
    end
    if (ADDR_W > REV_W) begin : g_upper
        assign rev_ptr[ADDR_W-1:REV_W] = cur_ptr[ADDR_W-1:REV_W];
    end
endmodule

// File: rtl/addr_step_unit.sv
module addr_step_unit
    import addr_step_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned SEL_LSB = DEF_SEL_LSB,
    parameter int unsigned SEL_W   = DEF_SEL_W,
    parameter int unsigned LEN_W   = DEF_LEN_W,
    parameter int unsigned MIN_LEN = DEF_MIN_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] modifier,
    input  logic [ADDR_W-1:0] circ_base,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_ptr
);
    localparam int unsigned REV_W = ADDR_W / 2;

    step_state_e       state_q, state_d;
    step_mode_e        mode_sel;
    logic [SEL_W-1:0]  fld_k;
    logic [LEN_W-1:0]  fld_len;
    logic [ADDR_W-1:0] win_lo, win_hi;
    logic [ADDR_W-1:0] circ_next, brev_next, step_next;
    logic [ADDR_W-1:0] ptr_q;

    assign mode_sel = step_mode_e'(mode);
    assign fld_k    = modifier[SEL_LSB +: SEL_W];
    assign fld_len  = modifier[LEN_W-1:0];

    step_window #(
        .ADDR_W(ADDR_W), .SEL_W(SEL_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)
    ) u_window (
        .sel_k(fld_k), .buf_len(fld_len), .cur_ptr(ptr),
        .base_reg(circ_base), .win_lo(win_lo), .win_hi(win_hi)
    );

    step_wrap #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W)
    ) u_wrap (
        .cur_ptr(ptr), .incr(offset), .buf_len(fld_len),
        .win_lo(win_lo), .win_hi(win_hi), .next_ptr(circ_next)
    );

    step_bitrev #(
        .ADDR_W(ADDR_W), .REV_W(REV_W)
    ) u_brev (
        .cur_ptr(ptr), .rev_ptr(brev_next)
    );

    always_comb begin
        unique case (mode_sel)
            MODE_CIRC: step_next = circ_next;
            MODE_BREV: step_next = brev_next;
            default:   step_next = circ_next;
        endcase
    end

    // Next-state logic: accept or drain.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result register, loaded only on an accepted request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (in_valid) begin
            ptr_q <= step_next;
        end
    end

    // Output process.
    always_comb begin
        out_ptr = ptr_q;
        unique case (state_q)
            ST_IDLE: out_valid = 1'b0;
            ST_EMIT: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/addr_step_chk.sv
module addr_step_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mode,
    input logic [ADDR_W-1:0] ptr,
    input logic [ADDR_W-1:0] offset,
    input logic [ADDR_W-1:0] modifier,
    input logic [ADDR_W-1:0] circ_base,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_ptr
);
    localparam int unsigned HALF = ADDR_W / 2;

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!out_valid && out_ptr == '0);
        end
    end

    // R2
    strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_ptr));

    // R8
    upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode) |=> out_ptr[ADDR_W-1:HALF] == $past(ptr[ADDR_W-1:HALF]));

    // R8
    mirror_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode) |=> (out_ptr[0] == $past(ptr[HALF-1])
                                && out_ptr[HALF-1] == $past(ptr[0])));

    // R4
    base_window_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode && offset == '0 && modifier[27:24] == 4'd0
         && modifier[16:0] >= 17'd4 && ptr >= circ_base
         && ptr < circ_base + ADDR_W'(modifier[16:0])
         && circ_base + ADDR_W'(modifier[16:0]) > circ_base)
        |=> out_ptr == $past(ptr));
endmodule

bind addr_step_unit addr_step_chk #(.ADDR_W(ADDR_W)) u_addr_step_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .ptr(ptr), .offset(offset), .modifier(modifier), .circ_base(circ_base),
    .out_valid(out_valid), .out_ptr(out_ptr)
);

// File: tb/tb_addr_step_unit.sv
`timescale 1ns/1ps
module tb_addr_step_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] ptr = '0, offset = '0, modifier = '0, circ_base = '0;
    logic        out_valid;
    logic [31:0] out_ptr;
    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    addr_step_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .ptr(ptr), .offset(offset), .modifier(modifier), .circ_base(circ_base),
        .out_valid(out_valid), .out_ptr(out_ptr)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected circular result and which rule decided it.
    function automatic logic [31:0] ref_circ(input logic [31:0] p, input logic [31:0] o,
                                             input logic [31:0] m, input logic [31:0] b,
                                             output string rule);
        logic [3:0]  k;
        logic [31:0] l, s, e, c, msk;
        k = m[27:24];
        l = {15'd0, m[16:0]};
        if (k == 0 && l >= 4) begin
            s = b; e = b + l;
        end else begin
            msk = (32'd1 << (k + 2)) - 32'd1;
            s = p & ~msk; e = s | l;
        end
        c = p + o;
        if (c >= e) begin rule = "R6"; return c - l; end
        if (c < s)  begin rule = "R7"; return c + l; end
        rule = (k == 0 && l >= 4) ? "R4" : "R5";
        return c;
    endfunction

    function automatic logic [31:0] ref_brev(input logic [31:0] p);
        logic [31:0] r;
        r = p;
        for (int i = 0; i < 16; i++) r[i] = p[15 - i];
        return r;
    endfunction

    // Present one request at a negedge and check it at the next negedge.
    task automatic run_op(input logic md, input logic [31:0] p, input logic [31:0] o,
                          input logic [31:0] m, input logic [31:0] b,
                          input logic [31:0] m_ref);
        logic [31:0] exp;
        string rule;
        in_valid = 1'b1; mode = md; ptr = p; offset = o; modifier = m; circ_base = b;
        if (md) begin exp = ref_brev(p); rule = "R8"; end
        else exp = ref_circ(p, o, m_ref, b, rule);
        @(negedge clk);
        check("R2 valid", {31'd0, out_valid}, 32'd1);
        check(rule, out_ptr, exp);
    endtask

    task automatic idle_check();
        logic [31:0] held;
        held = out_ptr;
        in_valid = 1'b0;
        ptr = ~ptr; offset = 32'h5; modifier = 32'h0000_0010; mode = 1'b0;
        @(negedge clk);
        check("R2 drop", {31'd0, out_valid}, 32'd0);
        check("R2 hold", out_ptr, held);
    endtask

    initial begin
        #900000;
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int lens_e[5];
        int lens_l[6];
        int offs_l[5];
        lens_e = '{4, 5, 16, 100, 131071};
        lens_l = '{0, 1, 3, 9, 64, 131071};
        offs_l = '{-5, -1, 0, 1, 5};
        repeat (3) @(negedge clk);
        // R1
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 ptr", out_ptr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle", {31'd0, out_valid}, 32'd0);

        // R4 R6 R7: explicit window, pointer at edges, offsets up to +-L
        foreach (lens_e[li]) begin
            for (int bi = 0; bi < 2; bi++) begin
                logic [31:0] b, m;
                int l;
                l = lens_e[li];
                b = (bi == 0) ? 32'h0000_1000 : 32'h7FFF_0010;
                m = {15'd0, 17'(l)};
                for (int pi = 0; pi < 4; pi++) begin
                    int idx;
                    idx = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? l / 2 : l - 1;
                    for (int oi = 0; oi < 7; oi++) begin
                        int o;
                        o = (oi == 0) ? -l : (oi == 1) ? -3 : (oi == 2) ? -1 :
                            (oi == 3) ? 0 : (oi == 4) ? 1 : (oi == 5) ? 3 : l;
                        if (o <= l && -o <= l)
                            run_op(1'b0, b + 32'(idx), 32'(o), m, b, m);
                    end
                end
            end
        end
        idle_check();

        // R5: every K, short and long lengths, K=0 with L below 4 included
        for (int k = 0; k < 16; k++) begin
            foreach (lens_l[li]) begin
                for (int pi = 0; pi < 3; pi++) begin
                    logic [31:0] p, m;
                    p = 32'h3000_0000 | (32'h0001_2345 * 32'(pi + 1) + 32'(k * 7));
                    m = {4'd0, 4'(k), 7'd0, 17'(lens_l[li])};
                    foreach (offs_l[oi])
                        run_op(1'b0, p, 32'(offs_l[oi]), m, 32'h0000_8000, m);
                end
            end
        end
        idle_check();

        // R3: junk in the ignored modifier bits
        for (int j = 0; j < 64; j++) begin
            logic [31:0] clean, junk, p;
            clean = {4'd0, 4'(j % 3), 7'd0, 17'(4 + j * 3)};
            junk  = clean | {4'(j + 1), 4'd0, 7'(j * 5 + 1), 17'd0};
            p = 32'h0000_2000 + 32'(j);
            run_op(1'b0, p, 32'(j % 9) - 32'd4, junk, 32'h0000_2000, clean);
        end
        idle_check();

        // R8: single bits, then random values with junk circular inputs
        for (int i = 0; i < 32; i++)
            run_op(1'b1, 32'd1 << i, $urandom, $urandom, $urandom, 32'd0);
        for (int i = 0; i < 300; i++)
            run_op(1'b1, $urandom, $urandom, $urandom, $urandom, 32'd0);
        idle_check();

        // R6 R7 random circular requests with |offset| <= L
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] m, b, p;
            int l, o;
            m = $urandom & 32'h0F01_FFFF;
            if (i % 2 == 0) m[27:24] = 4'd0;
            l = int'(m[16:0]);
            b = $urandom;
            p = (m[27:24] == 0 && l >= 4) ? b + 32'($urandom_range(0, l - 1)) : $urandom;
            o = int'($urandom_range(0, 2 * l)) - l;
            run_op(1'b0, p, 32'(o), m, b, m);
        end
        idle_check();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule